// File: doc/BRIEF.md
# Single-Precision Compare Flag Unit

This block compares two single-precision floating-point operands and turns the result into a one-bit condition flag. It also produces a pulse that reports an invalid-operand exception and an indication that the opcode was not recognised. A 6-bit compare opcode selects one of ten predicates. Each predicate is a five-bit condition mask: an unordered enable, an equal enable, a less enable, a greater enable, and a signal-on-unordered enable.

From the two operands the block derives four relations: unordered, equal, less-than and greater-than. The flag is the OR of these relations, each one gated by its enable bit. The four relations give every ordered predicate and also the unordered-aware predicates that a C math library needs. Only predicates with the signal-on-unordered bit set report an exception when an operand is NaN.

Operands, opcode and a valid strobe are presented together. Every output is registered and appears in the cycle after the strobe. Outputs are zero in every cycle without a result. Rounding, double precision and status-register update belong to the surrounding pipeline.

Top module: `fcmp_flag_unit`

## Requirements
- R1: `res_valid` is high exactly in the cycle after a cycle with `cmp_valid` high. In any cycle where `res_valid` is low, `cmp_flag`, `cmp_invalid` and `cmp_badop` are all 0.
- R2: While `rst` is high, and in the first cycle after it, every output is 0.
- R3: An operand is NaN when its exponent field (bits 30:23) is all ones and its fraction field (bits 22:0) is nonzero. The unordered relation is true when either operand is NaN. Infinity (fraction zero) is not NaN.
- R4: Positive zero (0x00000000) and negative zero (0x80000000) compare equal, and neither is less than the other.
- R5: Less-than follows sign-magnitude order: a negative operand is below a positive one, and between two negative operands the larger magnitude is the smaller value.
- R6: The greater-than relation is true exactly when B is less than A.
- R7: The ordered opcodes use these masks (bits U E L G X): 0x08 equal = 01000, 0x09 not-equal = 10110, 0x0a greater = 00011, 0x0b greater-or-equal = 01011, 0x0c less = 00101, 0x0d less-or-equal = 01101. The flag is (U&un)|(E&eq)|(L&lt)|(G&gt).
- R8: The unordered-aware opcodes use these masks: 0x28 unordered = 10000, 0x29 unordered-or-less = 10100, 0x2a unordered-or-less-or-equal = 11100, 0x2b unordered-or-equal = 11000.
- R9: `cmp_invalid` is 1 exactly when the mask has X set and the operands are unordered. It is therefore never raised by opcodes 0x28 to 0x2b.
- R10: Any opcode other than the ten listed sets `cmp_badop` and gives `cmp_flag` = 0 and `cmp_invalid` = 0.
- R11: When either operand is NaN, the equal, less and greater relations are all 0, even for bit-identical NaN operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_valid | input | 1 | Operands and opcode are valid this cycle |
| cmp_op | input | 6 | Compare opcode |
| opnd_a | input | 32 | Operand A, single precision |
| opnd_b | input | 32 | Operand B, single precision |
| res_valid | output | 1 | Registered result is valid |
| cmp_flag | output | 1 | Condition flag |
| cmp_invalid | output | 1 | Invalid-operand exception pulse |
| cmp_badop | output | 1 | Unrecognised opcode |

## Verification
Uniform random 32-bit patterns almost never hit the cases that matter here. NaN needs a saturated exponent. Equality between operands is rare. A signed zero on both sides is rarer still. Random operands therefore come from a weighted mix of classes: NaNs with random nonzero fractions, infinities of either sign, both signed zeros, values near one with few fraction bits, and a copy of the other operand, sometimes with its sign flipped. In this way equal magnitudes, both-negative pairs and mixed NaN/number pairs appear often for every opcode. Directed vectors pin down the single cases: bit-identical NaNs under the equal predicate, and zero against negative zero.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

  localparam int OPC_W = 6;

  typedef struct packed {
    logic u;   // pass when unordered
    logic e;   // pass when equal
    logic l;   // pass when A below B
    logic g;   // pass when A above B
    logic x;   // signal exception when unordered
  } cond_mask_t;

  localparam logic [OPC_W-1:0] OP_ORD_EQ  = 6'h08;
  localparam logic [OPC_W-1:0] OP_ORD_NE  = 6'h09;
  localparam logic [OPC_W-1:0] OP_ORD_GT  = 6'h0a;
  localparam logic [OPC_W-1:0] OP_ORD_GE  = 6'h0b;
  localparam logic [OPC_W-1:0] OP_ORD_LT  = 6'h0c;
  localparam logic [OPC_W-1:0] OP_ORD_LE  = 6'h0d;
  localparam logic [OPC_W-1:0] OP_UNO     = 6'h28;
  localparam logic [OPC_W-1:0] OP_UNO_LT  = 6'h29;
  localparam logic [OPC_W-1:0] OP_UNO_LE  = 6'h2a;
  localparam logic [OPC_W-1:0] OP_UNO_EQ  = 6'h2b;

  typedef struct packed {
    logic un;
    logic eq;
    logic lt;
    logic gt;
  } cmp_rel_t;

endpackage

// File: rtl/fcmp_decode.sv
module fcmp_decode
  import fcmp_pkg::*;
(
  input  logic [OPC_W-1:0] opc,
  output cond_mask_t       mask,
  output logic             illegal
);

  always_comb begin
    mask    = '0;
    illegal = 1'b0;
    case (opc)
      OP_ORD_EQ: mask = '{u:1'b0, e:1'b1, l:1'b0, g:1'b0, x:1'b0};
      OP_ORD_NE: mask = '{u:1'b1, e:1'b0, l:1'b1, g:1'b1, x:1'b0};
      OP_ORD_GT: mask = '{u:1'b0, e:1'b0, l:1'b0, g:1'b1, x:1'b1};
      OP_ORD_GE: mask = '{u:1'b0, e:1'b1, l:1'b0, g:1'b1, x:1'b1};
      OP_ORD_LT: mask = '{u:1'b0, e:1'b0, l:1'b1, g:1'b0, x:1'b1};
      OP_ORD_LE: mask = '{u:1'b0, e:1'b1, l:1'b1, g:1'b0, x:1'b1};
      OP_UNO:    mask = '{u:1'b1, e:1'b0, l:1'b0, g:1'b0, x:1'b0};
      OP_UNO_LT: mask = '{u:1'b1, e:1'b0, l:1'b1, g:1'b0, x:1'b0};
      OP_UNO_LE: mask = '{u:1'b1, e:1'b1, l:1'b1, g:1'b0, x:1'b0};
      OP_UNO_EQ: mask = '{u:1'b1, e:1'b1, l:1'b0, g:1'b0, x:1'b0};
      default:   illegal = 1'b1;
    endcase
  end

endmodule

// File: rtl/fcmp_classify.sv
module fcmp_classify #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W     = 1 + EXP_W + MAN_W,
  localparam int MAG_W = EXP_W + MAN_W
) (
  input  logic [W-1:0]     val,
  output logic             sign,
  output logic [MAG_W-1:0] mag,
  output logic             is_nan,
  output logic             is_zero
);

  logic [EXP_W-1:0] expo;
  logic [MAN_W-1:0] frac;

  always_comb begin
    sign    = val[W-1];
    mag     = val[MAG_W-1:0];
    expo    = val[MAG_W-1:MAN_W];
    frac    = val[MAN_W-1:0];
    is_nan  = (&expo) && (|frac);
    is_zero = ~|mag;
  end

endmodule

// File: rtl/fcmp_order_less.sv
module fcmp_order_less #(
  parameter int MAG_W = 31
) (
  input  logic             sign_x,
  input  logic [MAG_W-1:0] mag_x,
  input  logic             sign_y,
  input  logic [MAG_W-1:0] mag_y,
  input  logic             zeros,
  output logic             x_below_y
);

  logic mag_lt;
  logic mag_gt;

  always_comb begin
    mag_lt = mag_x < mag_y;
    mag_gt = mag_x > mag_y;
    if (zeros)                 x_below_y = 1'b0;
    else if (sign_x != sign_y) x_below_y = sign_x;
    else if (sign_x)           x_below_y = mag_gt;
    else                       x_below_y = mag_lt;
  end

endmodule

// File: rtl/fcmp_flag_unit.sv
module fcmp_flag_unit
  import fcmp_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W     = 1 + EXP_W + MAN_W,
  localparam int MAG_W = EXP_W + MAN_W,
  localparam int NOPND = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmp_valid,
  input  logic [OPC_W-1:0] cmp_op,
  input  logic [W-1:0]     opnd_a,
  input  logic [W-1:0]     opnd_b,
  output logic             res_valid,
  output logic             cmp_flag,
  output logic             cmp_invalid,
  output logic             cmp_badop
);

  logic [W-1:0]     opnd     [NOPND];
  logic             sgn      [NOPND];
  logic [MAG_W-1:0] mag      [NOPND];
  logic             nan      [NOPND];
  logic             zro      [NOPND];
  logic             below    [NOPND];

  assign opnd[0] = opnd_a;
  assign opnd[1] = opnd_b;

  genvar gi;
  generate
    for (gi = 0; gi < NOPND; gi++) begin : g_opnd
      fcmp_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
        .val     (opnd[gi]),
        .sign    (sgn[gi]),
        .mag     (mag[gi]),
        .is_nan  (nan[gi]),
        .is_zero (zro[gi])
      );
    end
  endgenerate

  logic both_zero;
  assign both_zero = zro[0] & zro[1];

  // Instance 0 tests A<B, instance 1 tests B<A (used for greater-than).
  generate
    for (gi = 0; gi < NOPND; gi++) begin : g_less
      fcmp_order_less #(.MAG_W(MAG_W)) u_less (
        .sign_x    (sgn[gi]),
        .mag_x     (mag[gi]),
        .sign_y    (sgn[NOPND-1-gi]),
        .mag_y     (mag[NOPND-1-gi]),
        .zeros     (both_zero),
        .x_below_y (below[gi])
      );
    end
  endgenerate

  cmp_rel_t rel;
  always_comb begin
    rel.un = nan[0] | nan[1];
    rel.eq = ~rel.un & ((opnd_a == opnd_b) | both_zero);
    rel.lt = ~rel.un & below[0];
    rel.gt = ~rel.un & below[1];
  end

  cond_mask_t mask;
  logic       illegal;

  fcmp_decode u_dec (
    .opc     (cmp_op),
    .mask    (mask),
    .illegal (illegal)
  );

  logic flag_nx;
  logic inv_nx;
  always_comb begin
    flag_nx = (mask.u & rel.un) | (mask.e & rel.eq) |
              (mask.l & rel.lt) | (mask.g & rel.gt);
    inv_nx  = mask.x & rel.un;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid   <= 1'b0;
      cmp_flag    <= 1'b0;
      cmp_invalid <= 1'b0;
      cmp_badop   <= 1'b0;
    end else begin
      res_valid   <= cmp_valid;
      cmp_flag    <= cmp_valid & flag_nx;
      cmp_invalid <= cmp_valid & inv_nx;
      cmp_badop   <= cmp_valid & illegal;
    end
  end

endmodule

// File: rtl/fcmp_flag_unit_chk.sv
module fcmp_flag_unit_chk (
  input logic        clk,
  input logic        rst,
  input logic        cmp_valid,
  input logic [5:0]  cmp_op,
  input logic [31:0] opnd_a,
  input logic [31:0] opnd_b,
  input logic        res_valid,
  input logic        cmp_flag,
  input logic        cmp_invalid,
  input logic        cmp_badop
);

  logic a_nan;
  logic b_nan;
  assign a_nan = (&opnd_a[30:23]) && (|opnd_a[22:0]);
  assign b_nan = (&opnd_b[30:23]) && (|opnd_b[22:0]);

  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (rst)
    cmp_valid |=> res_valid);

  assert_idle_follows_R1: assert property (@(posedge clk) disable iff (rst)
    !cmp_valid |=> !res_valid);

  assert_quiet_when_idle_R1: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> !(cmp_flag || cmp_invalid || cmp_badop));

  assert_badop_silent_R10: assert property (@(posedge clk) disable iff (rst)
    cmp_badop |-> !cmp_flag && !cmp_invalid);

  assert_unordered_family_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    (cmp_valid && cmp_op[5:2] == 4'b1010) |=> !cmp_invalid);

  assert_nan_not_equal_R11: assert property (@(posedge clk) disable iff (rst)
    (cmp_valid && cmp_op == 6'h08 && (a_nan || b_nan)) |=> !cmp_flag);

  assert_signed_zero_equal_R4: assert property (@(posedge clk) disable iff (rst)
    (cmp_valid && cmp_op == 6'h08 && opnd_a[30:0] == 31'd0 && opnd_b[30:0] == 31'd0)
      |=> cmp_flag);

endmodule

bind fcmp_flag_unit fcmp_flag_unit_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .cmp_valid   (cmp_valid),
  .cmp_op      (cmp_op),
  .opnd_a      (opnd_a),
  .opnd_b      (opnd_b),
  .res_valid   (res_valid),
  .cmp_flag    (cmp_flag),
  .cmp_invalid (cmp_invalid),
  .cmp_badop   (cmp_badop)
);

// File: tb/fcmp_flag_unit_tb.sv
module fcmp_flag_unit_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmp_valid = 1'b0;
  logic [5:0]  cmp_op = '0;
  logic [31:0] opnd_a = '0;
  logic [31:0] opnd_b = '0;
  logic        res_valid, cmp_flag, cmp_invalid, cmp_badop;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  fcmp_flag_unit u_dut (
    .clk(clk), .rst(rst), .cmp_valid(cmp_valid), .cmp_op(cmp_op),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .res_valid(res_valid),
    .cmp_flag(cmp_flag), .cmp_invalid(cmp_invalid), .cmp_badop(cmp_badop)
  );

  function automatic bit is_nan(input logic [31:0] v);
    return (v[30:23] == 8'hff) && (v[22:0] != 0);
  endfunction

  // Monotone unsigned key for non-NaN values; both zeros share one key.
  function automatic logic [31:0] okey(input logic [31:0] v);
    if (v[30:0] == 0) return 32'h8000_0000;
    return v[31] ? ~v : (v | 32'h8000_0000);
  endfunction

  // Returns {flag, invalid, badop}
  function automatic logic [2:0] model(input logic [31:0] a, input logic [31:0] b,
                                       input logic [5:0] op);
    logic [4:0] m;   // U E L G X
    bit un, eq, lt, gt, ok;
    ok = 1'b1;
    case (op)
      6'h08: m = 5'b01000;  6'h09: m = 5'b10110;
      6'h0a: m = 5'b00011;  6'h0b: m = 5'b01011;
      6'h0c: m = 5'b00101;  6'h0d: m = 5'b01101;
      6'h28: m = 5'b10000;  6'h29: m = 5'b10100;
      6'h2a: m = 5'b11100;  6'h2b: m = 5'b11000;
      default: begin m = 5'b0; ok = 1'b0; end
    endcase
    un = is_nan(a) || is_nan(b);
    eq = !un && okey(a) == okey(b);
    lt = !un && okey(a) <  okey(b);
    gt = !un && okey(b) <  okey(a);
    return {(m[4] & un) | (m[3] & eq) | (m[2] & lt) | (m[1] & gt), m[0] & un, !ok};
  endfunction

  function automatic string req_of(input logic [5:0] op);
    if (op inside {6'h08, 6'h09, 6'h0a, 6'h0b, 6'h0c, 6'h0d}) return "R7";
    if (op inside {6'h28, 6'h29, 6'h2a, 6'h2b}) return "R8";
    return "R10";
  endfunction

  // Called at a negedge: drives one vector, checks it at the next negedge.
  task automatic apply(input logic [31:0] a, input logic [31:0] b,
                       input logic [5:0] op, input string req);
    logic [3:0] exp_v, got_v;
    cmp_valid = 1'b1; cmp_op = op; opnd_a = a; opnd_b = b;
    @(negedge clk);
    exp_v = {1'b1, model(a, b, op)};
    got_v = {res_valid, cmp_flag, cmp_invalid, cmp_badop};
    n_vec++;
    if (got_v !== exp_v) begin
      n_fail++;
      $display("FAIL %s a=%h b=%h op=%h valid/flag/inv/bad actual=%b expected=%b",
               req, a, b, op, got_v, exp_v);
    end
  endtask

  task automatic check_idle(input string req);
    logic [3:0] got_v;
    got_v = {res_valid, cmp_flag, cmp_invalid, cmp_badop};
    n_vec++;
    if (got_v !== 4'b0000) begin
      n_fail++;
      $display("FAIL %s idle outputs actual=%b expected=0000", req, got_v);
    end
  endtask

  function automatic logic [31:0] gen_opnd(input logic [31:0] other);
    logic [31:0] r;
    r = $urandom;
    case ($urandom % 8)
      0, 1: return r;
      2:    return {r[31], 8'hff, r[22:0] | 23'h1};
      3:    return {r[31], 8'hff, 23'h0};
      4:    return {r[31], 31'h0};
      5:    return {r[31], 8'd127 + 8'(r[1:0]), r[22:20], 20'h0};
      6:    return other;
      default: return {~other[31], other[30:0]};
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    cmp_valid = 1'b1; cmp_op = 6'h28; opnd_a = 32'h7fc0_0000;
    repeat (3) @(negedge clk);
    check_idle("R2");                  // reset holds outputs low despite strobe
    cmp_valid = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    check_idle("R2");

    // R3: NaN detection, infinity is ordered
    apply(32'h7fc0_0000, 32'h3f80_0000, 6'h28, "R3");
    apply(32'h3f80_0000, 32'hff80_0001, 6'h28, "R3");
    apply(32'h7f80_0000, 32'h7f80_0000, 6'h08, "R3");
    apply(32'h7f80_0000, 32'h7f80_0000, 6'h28, "R3");
    // R4: signed zeros
    apply(32'h0000_0000, 32'h8000_0000, 6'h08, "R4");
    apply(32'h8000_0000, 32'h0000_0000, 6'h0c, "R4");
    apply(32'h0000_0000, 32'h8000_0000, 6'h0a, "R4");
    // R5: sign-magnitude order
    apply(32'hc000_0000, 32'hbf80_0000, 6'h0c, "R5");
    apply(32'hbf80_0000, 32'h3f80_0000, 6'h0c, "R5");
    apply(32'h3f80_0000, 32'hbf80_0000, 6'h0c, "R5");
    // R6: greater is B below A
    apply(32'h4000_0000, 32'h3f80_0000, 6'h0a, "R6");
    apply(32'hbf80_0000, 32'hc000_0000, 6'h0b, "R6");
    // R9: exception only with X set
    apply(32'h7fc0_0000, 32'h3f80_0000, 6'h0c, "R9");
    apply(32'h7fc0_0000, 32'h3f80_0000, 6'h29, "R9");
    apply(32'h7fc0_0000, 32'h3f80_0000, 6'h09, "R9");
    // R10: unknown opcodes
    apply(32'h3f80_0000, 32'h3f80_0000, 6'h00, "R10");
    apply(32'h7fc0_0000, 32'h3f80_0000, 6'h2c, "R10");
    // R11: identical NaNs are not equal
    apply(32'h7fc0_0001, 32'h7fc0_0001, 6'h08, "R11");
    apply(32'h7fc0_0001, 32'h7fc0_0001, 6'h09, "R11");
    apply(32'h7fc0_0001, 32'h7fc0_0001, 6'h2b, "R11");
    // R1: idle cycle after a burst
    cmp_valid = 1'b0;
    @(negedge clk);
    check_idle("R1");

    for (int i = 0; i < 4000; i++) begin
      logic [31:0] a, b;
      logic [5:0]  op;
      a = gen_opnd($urandom);
      b = gen_opnd(a);
      case ($urandom % 12)
        0:  op = 6'($urandom);
        1:  op = 6'h0a + 6'($urandom % 4);
        default: op = ($urandom % 2) ? 6'h08 + 6'($urandom % 6)
                                     : 6'h28 + 6'($urandom % 4);
      endcase
      apply(a, b, op, req_of(op));
      if (($urandom % 16) == 0) begin
        cmp_valid = 1'b0;
        @(negedge clk);
        check_idle("R1");
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule